// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block passes 36-bit data between two ports, A and B, through two independent paths. The A-to-B path drives port B and the B-to-A path drives port A. Each path has its own clock, latch-enable and output-enable inputs, and one storage element. That element gives three behaviours: a transparent latch while latch-enable is high, a held value while latch-enable is low and the clock does not rise, and an edge-clocked register that captures on each rising clock edge while latch-enable is low.

Transparency is a combinational bypass in front of a register. The register loads on every rising edge of its own clock, whatever the latch-enable level. So when latch-enable drops, the output shows the input sampled at the last rising edge. Three-state outputs are modelled as a data bus and an enable bit per port. The A-to-B enable is active high and the B-to-A enable is active low. The enable outputs follow their enable inputs without a register. The two directions do not arbitrate. The system drives the pins so that they never contend.

Top module: `bus_xcvr36`

## Requirements
- R1: While le_ab is 1, b_dat equals a_in combinationally, with no clock edge needed. While le_ba is 1, a_dat equals b_in in the same way.
- R2: When le_ab is 0, a rising edge of clk_ab stores a_in, and b_dat shows that value after the edge.
- R3: When le_ab is 0 and clk_ab does not rise, b_dat keeps its stored value while a_in changes.
- R4: The register loads on every rising clk_ab edge, including edges while le_ab is 1. After le_ab falls, b_dat equals a_in as sampled at the last rising clk_ab edge, or zero if no edge has come since reset.
- R5: b_en equals oe_ab (1 = port B driven, 0 = high impedance). Changing oe_ab never alters b_dat or the stored value.
- R6: The B-to-A path mirrors R1 to R4, using le_ba, clk_ba and b_in, and drives a_dat.
- R7: a_en is the inverse of oe_ba_n (oe_ba_n = 0 drives port A). Changing oe_ba_n never alters a_dat.
- R8: A rising edge of a path's clock while rst_n is 0 clears that path's stored value to zero. The enable outputs still follow their enable inputs during reset.
- R9: A clock edge, reset or input change in one direction leaves the stored value and output of the other direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B capture clock, rising edge |
| clk_ba | input | 1 | B-to-A capture clock, rising edge |
| rst_n | input | 1 | Synchronous active-low clear of both storage registers |
| le_ab | input | 1 | A-to-B latch-enable, 1 = transparent |
| oe_ab | input | 1 | A-to-B output enable, active high |
| a_in | input | 36 | Data received from port A |
| le_ba | input | 1 | B-to-A latch-enable, 1 = transparent |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_in | input | 36 | Data received from port B |
| b_dat | output | 36 | Data driven onto port B |
| b_en | output | 1 | Drive enable for port B |
| a_dat | output | 36 | Data driven onto port A |
| a_en | output | 1 | Drive enable for port A |

## Verification
Transparent data and both enable outputs are combinational, so the bench checks them one time step after it changes an input, with no clock edge in between. A captured value appears one register after the rising edge of its own gated clock. The bench changes inputs and opens the clock gate at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Hold and independence checks run with the other path's clock gate kept closed, so any change at that path's output is caught.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned XW = 36;

  typedef enum logic {
    OE_ACT_LOW  = 1'b0,
    OE_ACT_HIGH = 1'b1
  } oe_pol_e;

  // output data: live input while transparent, else the stored word
  function automatic logic [XW-1:0] pick_out(input logic le,
                                             input logic [XW-1:0] live,
                                             input logic [XW-1:0] held);
    return le ? live : held;
  endfunction

  // pin enable from the raw enable input and its polarity
  function automatic logic drive_en(input logic oe_raw, input oe_pol_e pol);
    return (pol == OE_ACT_HIGH) ? oe_raw : ~oe_raw;
  endfunction
endpackage

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  // loads on every rising edge; transparency is handled downstream
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= din;
  end
endmodule

// File: rtl/ubt_outsel.sv
module ubt_outsel
  import ubt_pkg::*;
#(
  parameter int unsigned W   = XW,
  parameter oe_pol_e     POL = OE_ACT_HIGH
) (
  input  logic         le,
  input  logic         oe_raw,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] dout,
  output logic         den
);
  always_comb begin
    dout = pick_out(le, live, held);
    den  = drive_en(oe_raw, POL);
  end
endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int unsigned W   = XW,
  parameter oe_pol_e     POL = OE_ACT_HIGH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         oe_raw,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         den
);
  logic [W-1:0] stored_w;

  ubt_store #(.W(W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .q    (stored_w)
  );

  ubt_outsel #(.W(W), .POL(POL)) u_sel (
    .le    (le),
    .oe_raw(oe_raw),
    .live  (din),
    .held  (stored_w),
    .dout  (dout),
    .den   (den)
  );

  // R1
  always_comb begin
    if (le) transparent_chk: assert (dout == din);
  end

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (le || dout == $past(din)));

  // R5
  en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(oe_raw) |-> $stable(den));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !le) |-> dout == '0);
endmodule

// File: rtl/bus_xcvr36.sv
module bus_xcvr36
  import ubt_pkg::*;
#(
  parameter int unsigned W = XW
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         le_ab,
  input  logic         oe_ab,
  input  logic [W-1:0] a_in,
  input  logic         le_ba,
  input  logic         oe_ba_n,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_dat,
  output logic         b_en,
  output logic [W-1:0] a_dat,
  output logic         a_en
);
  ubt_path #(.W(W), .POL(OE_ACT_HIGH)) u_ab (
    .clk   (clk_ab),
    .rst_n (rst_n),
    .le    (le_ab),
    .oe_raw(oe_ab),
    .din   (a_in),
    .dout  (b_dat),
    .den   (b_en)
  );

  ubt_path #(.W(W), .POL(OE_ACT_LOW)) u_ba (
    .clk   (clk_ba),
    .rst_n (rst_n),
    .le    (le_ba),
    .oe_raw(oe_ba_n),
    .din   (b_in),
    .dout  (a_dat),
    .den   (a_en)
  );

  // R7
  always_comb begin
    enable_polarity_chk: assert (a_en != oe_ba_n && b_en == oe_ab);
  end
endmodule

// File: tb/tb_bus_xcvr36.sv
module tb_bus_xcvr36;
  localparam int unsigned W = 36;

  typedef struct packed {
    logic         dir;   // 0 = A-to-B, 1 = B-to-A
    logic         le;
    logic         oe;    // raw pin value
    logic         tick;  // one rising edge on that path's clock
    logic [W-1:0] din;
    logic [W-1:0] dexp;
    logic         enexp;
  } vec_t;

  localparam logic [W-1:0] A1 = 36'h1_2345_6789, A2 = 36'hF_0F0F_0F0F,
                           A3 = 36'h8_0000_0001, A4 = 36'h5_5555_AAAA;
  localparam logic [W-1:0] B1 = 36'hA_BCDE_F012, B2 = 36'h0_0000_FFFF,
                           B3 = 36'h7_7777_0000, B5 = 36'hC_3C3C_3C3C;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, A1, 36'h0, 1'b1}, // R3/R4 hold zero
    '{1'b0, 1'b1, 1'b1, 1'b0, A1, A1,    1'b1}, // R1 transparent
    '{1'b0, 1'b0, 1'b1, 1'b0, A2, 36'h0, 1'b1}, // R4 no edge seen
    '{1'b0, 1'b0, 1'b1, 1'b1, A2, A2,    1'b1}, // R2 capture
    '{1'b0, 1'b0, 1'b0, 1'b0, A3, A2,    1'b0}, // R3/R5 hold, oe off
    '{1'b0, 1'b1, 1'b0, 1'b1, A3, A3,    1'b0}, // R1/R5
    '{1'b0, 1'b0, 1'b1, 1'b0, A4, A3,    1'b1}, // R4 last edge value
    '{1'b1, 1'b0, 1'b0, 1'b0, B1, 36'h0, 1'b1}, // R6/R7 hold zero
    '{1'b1, 1'b0, 1'b1, 1'b1, B1, B1,    1'b0}, // R6 capture, R7
    '{1'b1, 1'b1, 1'b0, 1'b0, B2, B2,    1'b1}, // R6 transparent
    '{1'b1, 1'b0, 1'b0, 1'b0, B3, B1,    1'b1}  // R6 hold
  };

  logic clk = 1'b0, run_ab = 1'b0, run_ba = 1'b0;
  logic rst_n, le_ab, oe_ab, le_ba, oe_ba_n;
  logic [W-1:0] a_in, b_in, b_dat, a_dat;
  logic b_en, a_en;
  logic clk_ab, clk_ba;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign clk_ab = clk & run_ab;
  assign clk_ba = clk & run_ba;

  bus_xcvr36 #(.W(W)) dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .le_ab(le_ab), .oe_ab(oe_ab), .a_in(a_in),
    .le_ba(le_ba), .oe_ba_n(oe_ba_n), .b_in(b_in),
    .b_dat(b_dat), .b_en(b_en), .a_dat(a_dat), .a_en(a_en)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; le_ab = 1'b0; oe_ab = 1'b1; le_ba = 1'b0; oe_ba_n = 1'b1;
    a_in = A4; b_in = B3;
    @(negedge clk); run_ab = 1'b1; run_ba = 1'b1;
    repeat (2) @(negedge clk);
    run_ab = 1'b0; run_ba = 1'b0;
    chk("R8 reset b_dat", b_dat, '0);
    chk("R8 reset a_dat", a_dat, '0);
    chk("R8/R5 b_en in reset", {35'd0, b_en}, 36'd1);
    chk("R8/R7 a_en in reset", {35'd0, a_en}, 36'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (!VECS[i].dir) begin
        le_ab = VECS[i].le; oe_ab = VECS[i].oe; a_in = VECS[i].din; run_ab = VECS[i].tick;
      end else begin
        le_ba = VECS[i].le; oe_ba_n = VECS[i].oe; b_in = VECS[i].din; run_ba = VECS[i].tick;
      end
      @(negedge clk);
      run_ab = 1'b0; run_ba = 1'b0;
      if (!VECS[i].dir) begin
        chk($sformatf("R1-R5 vec%0d b_dat", i), b_dat, VECS[i].dexp);
        chk($sformatf("R5 vec%0d b_en", i), {35'd0, b_en}, {35'd0, VECS[i].enexp});
      end else begin
        chk($sformatf("R6 vec%0d a_dat", i), a_dat, VECS[i].dexp);
        chk($sformatf("R7 vec%0d a_en", i), {35'd0, a_en}, {35'd0, VECS[i].enexp});
      end
    end

    // R9: edge on B-to-A only; A-to-B holds A3
    @(negedge clk); b_in = B5; run_ba = 1'b1;
    @(negedge clk); run_ba = 1'b0;
    chk("R9 b_dat untouched", b_dat, A3);
    chk("R9/R6 a_dat captured", a_dat, B5);

    // R3: input churn without an edge
    a_in = A1; #1 chk("R3 hold 1", b_dat, A3);
    a_in = A2; #1 chk("R3 hold 2", b_dat, A3);

    // R5: enable toggling while data moves
    oe_ab = 1'b0; le_ab = 1'b1; a_in = A4;
    #1 chk("R5 transparent oe off", b_dat, A4);
    chk("R5 b_en off", {35'd0, b_en}, 36'd0);
    oe_ab = 1'b1; a_in = A1;
    #1 chk("R5 data across oe rise", b_dat, A1);
    le_ab = 1'b0;
    #1 chk("R4 storage kept", b_dat, A3);
    oe_ba_n = 1'b1;
    #1 chk("R7 a_dat with oe_ba_n high", a_dat, B5);
    chk("R7 a_en off", {35'd0, a_en}, 36'd0);

    // R8: reset on A-to-B clock only
    @(negedge clk); rst_n = 1'b0; oe_ab = 1'b0; run_ab = 1'b1;
    @(negedge clk); run_ab = 1'b0; rst_n = 1'b1;
    chk("R8 b_dat cleared", b_dat, '0);
    chk("R8 b_en follows oe", {35'd0, b_en}, 36'd0);
    chk("R8/R9 a_dat kept", a_dat, B5);

    done = 1'b1;
    finish_run();
  end
endmodule